// File: doc/BRIEF.md
# Write-Masked PHY Control Register Bank

This block holds the configuration state of a storage-interface PHY and exposes it through a simple register port that has a valid strobe and a write flag. It has seven 16-bit control registers, each reached as a 32-bit word, and one read-only status word. Writes to a control register are self-masking. The upper half-word of every write says which lower bits the write may change, so software can set or clear a single field without first reading the register.

Several fields are decoded straight onto PHY control pins:
- analog power enable
- DLL enable
- a 3-bit drive-strength code
- output tap delay enable and its 4-bit select
- a 2-bit DLL frequency range

The status word reports two PHY inputs when it is read: pad calibration done and DLL ready.

Read data comes back registered, one clock after the request, together with a read-valid flag. Reset clears every control bit, so the PHY starts unpowered with its DLL off.

Top module: `phy_ctrl_bank`

## Requirements
- R1: After reset every control bit is 0: `phyPowerOn`, `dllEnable`, `driveCode`, `tapDelayEn`, `tapDelaySel` and `freqSel` are all 0, `rdValid` is 0, and every control register reads 0.
- R2: A write to a control register changes lower bit x only when bit x+16 of the written word is 1. Every other lower bit keeps its value, and a write whose upper half is 0 changes nothing.
- R3: A read request is answered one cycle after it is accepted. In that cycle `rdValid` is 1 and `rdData` holds the register's 16 stored bits in [15:0], with [31:16] equal to 0. `rdValid` is 0 in every cycle that does not follow a read request.
- R4: The seven control registers are at byte offsets 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14 and 0x18, and each one stores its value independently of the others.
- R5: In the register at 0x18, bit 0 drives `phyPowerOn` (1 = powered) and bit 1 drives `dllEnable`. Both follow the stored bits in the cycle after the write.
- R6: Bits 6:4 of the register at 0x18 drive `driveCode`. The codes are 0 = 50 ohm, 1 = 33 ohm, 2 = 66 ohm, 3 = 100 ohm and 4 = 40 ohm.
- R7: In the register at 0x00, bits 10:7 drive `tapDelaySel`, bit 11 drives `tapDelayEn`, and bits 13:12 drive `freqSel`. The `freqSel` codes are 0 = 200 MHz, 1 = 50 MHz, 2 = 100 MHz and 3 = 150 MHz.
- R8: Reading offset 0x20 returns `calDoneIn` in bit 6 and `dllReadyIn` in bit 5, sampled in the cycle of the request. All other bits read 0.
- R9: Writes to 0x20, to any unmapped offset and to any offset not a multiple of 4 change no register. Reads of unmapped offsets return 0 with `rdValid` set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 8 | Byte offset |
| reqWdata | input | 32 | Write word: [31:16] bit enables, [15:0] data |
| rdValid | output | 1 | Read data valid |
| rdData | output | 32 | Read data |
| calDoneIn | input | 1 | PHY pad calibration complete |
| dllReadyIn | input | 1 | PHY DLL locked |
| phyPowerOn | output | 1 | PHY analog power enable |
| dllEnable | output | 1 | DLL enable |
| driveCode | output | 3 | Drive-strength code |
| tapDelayEn | output | 1 | Output tap delay enable |
| tapDelaySel | output | 4 | Output tap delay select |
| freqSel | output | 2 | DLL frequency range |

## Verification
A wrong stored bit in a control register is visible on a decoded pin from the cycle after the write. For any register it is also visible on `rdData` one cycle after a read of that offset, so a failure of the mask rule shows at the next read. The bench keeps its own masked image of all seven registers and reads them back after every write pattern. A wrong address decode therefore shows up as a change in a register that should have kept its value. Wrong status wiring shows in the bit 6 and bit 5 values of a single read.

// File: rtl/phy_ctrl_bank_pkg.sv
`timescale 1ns/1ps
package phy_ctrl_bank_pkg;
  localparam int HALF_W     = 16;
  localparam int WORD_W     = 2 * HALF_W;
  localparam int CTRL_COUNT = 7;
  localparam int STATUS_IDX = 8;

  // register indices (byte offset / 4) whose fields are decoded
  localparam int CLK_REG_IDX = 0;
  localparam int PWR_REG_IDX = 6;

  // field positions inside their registers
  localparam int PWR_BIT      = 0;
  localparam int DLL_EN_BIT   = 1;
  localparam int DRV_LSB      = 4;
  localparam int DRV_W        = 3;
  localparam int TAP_SEL_LSB  = 7;
  localparam int TAP_SEL_W    = 4;
  localparam int TAP_EN_BIT   = 11;
  localparam int FREQ_LSB     = 12;
  localparam int FREQ_W       = 2;
  localparam int CAL_DONE_BIT = 6;
  localparam int DLL_RDY_BIT  = 5;

  typedef struct packed {
    logic [CTRL_COUNT-1:0] wrEn;
    logic [CTRL_COUNT-1:0] rdEn;
    logic                  rdStatus;
    logic                  rdAny;
  } bankStrobes_t;
endpackage

// File: rtl/phy_ctrl_decode.sv
`timescale 1ns/1ps
module phy_ctrl_decode
  import phy_ctrl_bank_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  output bankStrobes_t      strobes
);
  localparam int IDX_W = ADDR_W - 2;

  logic             aligned;
  logic [IDX_W-1:0] wordIdx;
  logic             isRead;
  logic             isWrite;

  assign aligned = (reqAddr[1:0] == 2'b00);
  assign wordIdx = reqAddr[ADDR_W-1:2];
  assign isRead  = reqValid && !reqWrite;
  assign isWrite = reqValid && reqWrite && aligned;

  for (genvar i = 0; i < CTRL_COUNT; i++) begin : g_sel
    assign strobes.wrEn[i] = isWrite && (wordIdx == IDX_W'(i));
    assign strobes.rdEn[i] = isRead && aligned && (wordIdx == IDX_W'(i));
  end

  assign strobes.rdStatus = isRead && aligned && (wordIdx == IDX_W'(STATUS_IDX));
  assign strobes.rdAny    = isRead;

  // R4: at most one control register is written per request
  assert_one_target_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes.wrEn));

  // R9: a request that is not a write never raises a write strobe
  assert_no_stray_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && reqWrite) |-> (strobes.wrEn == '0));
endmodule

// File: rtl/phy_ctrl_datapath.sv
`timescale 1ns/1ps
module phy_ctrl_datapath
  import phy_ctrl_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  bankStrobes_t      strobes,
  input  logic [WORD_W-1:0] reqWdata,
  input  logic              calDoneIn,
  input  logic              dllReadyIn,
  output logic              rdValid,
  output logic [WORD_W-1:0] rdData,
  output logic              phyPowerOn,
  output logic              dllEnable,
  output logic [DRV_W-1:0]  driveCode,
  output logic              tapDelayEn,
  output logic [TAP_SEL_W-1:0] tapDelaySel,
  output logic [FREQ_W-1:0] freqSel
);
  logic [HALF_W-1:0] ctrlReg [CTRL_COUNT];
  logic [HALF_W-1:0] bitEnable;
  logic [HALF_W-1:0] newBits;
  logic [WORD_W-1:0] rdNext;

  assign bitEnable = reqWdata[WORD_W-1:HALF_W];
  assign newBits   = reqWdata[HALF_W-1:0];

  for (genvar i = 0; i < CTRL_COUNT; i++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ctrlReg[i] <= '0;
      end else if (strobes.wrEn[i]) begin
        ctrlReg[i] <= (ctrlReg[i] & ~bitEnable) | (newBits & bitEnable);
      end
    end

    // R2: bits whose enable was 0 in the write keep their value
    assert_mask_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
      strobes.wrEn[i] |=>
        (((ctrlReg[i] ^ $past(ctrlReg[i])) & ~$past(bitEnable)) == '0));

    // R9: a register without a write strobe does not change
    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
      !strobes.wrEn[i] |=> $stable(ctrlReg[i]));
  end

  always_comb begin
    rdNext = '0;
    for (int i = 0; i < CTRL_COUNT; i++) begin
      if (strobes.rdEn[i]) rdNext[HALF_W-1:0] = ctrlReg[i];
    end
    if (strobes.rdStatus) begin
      rdNext[CAL_DONE_BIT] = calDoneIn;
      rdNext[DLL_RDY_BIT]  = dllReadyIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strobes.rdAny;
      rdData  <= rdNext;
    end
  end

  assign phyPowerOn  = ctrlReg[PWR_REG_IDX][PWR_BIT];
  assign dllEnable   = ctrlReg[PWR_REG_IDX][DLL_EN_BIT];
  assign driveCode   = ctrlReg[PWR_REG_IDX][DRV_LSB +: DRV_W];
  assign tapDelaySel = ctrlReg[CLK_REG_IDX][TAP_SEL_LSB +: TAP_SEL_W];
  assign tapDelayEn  = ctrlReg[CLK_REG_IDX][TAP_EN_BIT];
  assign freqSel     = ctrlReg[CLK_REG_IDX][FREQ_LSB +: FREQ_W];

  // R3: the upper half of read data is always zero
  assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (rdData[WORD_W-1:HALF_W] == '0));

  // R3: read data is valid exactly one cycle after a read request
  assert_rd_latency_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rdAny |=> rdValid);

  // R8: a status read returns the calibration input sampled at request time
  assert_status_cal_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rdStatus |=> (rdData[CAL_DONE_BIT] == $past(calDoneIn)));
endmodule

// File: rtl/phy_ctrl_bank.sv
`timescale 1ns/1ps
module phy_ctrl_bank
  import phy_ctrl_bank_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqWdata,
  output logic              rdValid,
  output logic [31:0]       rdData,
  input  logic              calDoneIn,
  input  logic              dllReadyIn,
  output logic              phyPowerOn,
  output logic              dllEnable,
  output logic [2:0]        driveCode,
  output logic              tapDelayEn,
  output logic [3:0]        tapDelaySel,
  output logic [1:0]        freqSel
);
  bankStrobes_t strobes;

  phy_ctrl_decode #(.ADDR_W(ADDR_W)) i_decode (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .strobes  (strobes)
  );

  phy_ctrl_datapath i_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .reqWdata    (reqWdata),
    .calDoneIn   (calDoneIn),
    .dllReadyIn  (dllReadyIn),
    .rdValid     (rdValid),
    .rdData      (rdData),
    .phyPowerOn  (phyPowerOn),
    .dllEnable   (dllEnable),
    .driveCode   (driveCode),
    .tapDelayEn  (tapDelayEn),
    .tapDelaySel (tapDelaySel),
    .freqSel     (freqSel)
  );
endmodule

// File: tb/test_phy_ctrl_bank.sv
`timescale 1ns/1ps
module test_phy_ctrl_bank;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [7:0]  reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic        rdValid;
  logic [31:0] rdData;
  logic        calDoneIn = 1'b0;
  logic        dllReadyIn = 1'b0;
  logic        phyPowerOn, dllEnable, tapDelayEn;
  logic [2:0]  driveCode;
  logic [3:0]  tapDelaySel;
  logic [1:0]  freqSel;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;
  logic [15:0] model [7];

  always #2.5 clk = ~clk;

  phy_ctrl_bank i_phy_ctrl_bank (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .rdValid(rdValid), .rdData(rdData),
    .calDoneIn(calDoneIn), .dllReadyIn(dllReadyIn), .phyPowerOn(phyPowerOn),
    .dllEnable(dllEnable), .driveCode(driveCode), .tapDelayEn(tapDelayEn),
    .tapDelaySel(tapDelaySel), .freqSel(freqSel)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [7:0] addr, input logic [31:0] data);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = addr; reqWdata = data;
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
    if (addr[1:0] == 2'b00 && addr[7:2] < 6'd7)
      model[addr[4:2]] = (model[addr[4:2]] & ~data[31:16]) | (data[15:0] & data[31:16]);
  endtask

  task automatic readReg(input logic [7:0] addr, output logic [31:0] value, input string req);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = addr;
    @(negedge clk);
    reqValid = 1'b0;
    check({req, " rdValid"}, {31'd0, rdValid}, 32'd1);
    value = rdData;
  endtask

  task automatic checkAllRegs(input string req);
    logic [31:0] v;
    for (int i = 0; i < 7; i++) begin
      readReg(8'(i * 4), v, req);
      check(req, v, {16'd0, model[i]});
    end
  endtask

  task automatic testReset();
    check("R1 power", {31'd0, phyPowerOn}, 32'd0);
    check("R1 dll", {31'd0, dllEnable}, 32'd0);
    check("R1 fields", {19'd0, driveCode, tapDelayEn, tapDelaySel, freqSel}, 32'd0);
    check("R1 rdValid", {31'd0, rdValid}, 32'd0);
    checkAllRegs("R1 regs");
    @(negedge clk);
    check("R3 rdValid idle", {31'd0, rdValid}, 32'd0);
  endtask

  task automatic testMaskedWrite();
    logic [31:0] v;
    writeReg(8'h04, 32'hFFFF_00AA);
    readReg(8'h04, v, "R2");
    check("R2 full mask", v, 32'h0000_00AA);
    writeReg(8'h04, 32'h000F_FFFF);
    readReg(8'h04, v, "R2");
    check("R2 low nibble set", v, 32'h0000_00AF);
    writeReg(8'h04, 32'h00F0_0000);
    readReg(8'h04, v, "R2");
    check("R2 clear nibble", v, 32'h0000_000F);
    writeReg(8'h04, 32'h0000_FFFF);
    readReg(8'h04, v, "R2");
    check("R2 zero mask", v, 32'h0000_000F);
    check("R3 upper zero", {16'd0, v[31:16]}, 32'd0);
  endtask

  task automatic testIndependent();
    for (int i = 0; i < 7; i++) writeReg(8'(i * 4), {16'hFFFF, 16'(16'h1111 * (i + 1) + 16'h0003)});
    checkAllRegs("R4 independent");
  endtask

  task automatic testPowerFields();
    writeReg(8'h18, 32'hFFFF_0000);
    writeReg(8'h18, 32'h0001_0001);
    check("R5 power on", {30'd0, dllEnable, phyPowerOn}, 32'd1);
    writeReg(8'h18, 32'h0002_0002);
    check("R5 dll on", {30'd0, dllEnable, phyPowerOn}, 32'd3);
    writeReg(8'h18, 32'h0070_0040);
    check("R6 drive 40ohm", {29'd0, driveCode}, 32'd4);
    check("R5 power kept", {30'd0, dllEnable, phyPowerOn}, 32'd3);
    writeReg(8'h18, 32'h0070_0030);
    check("R6 drive 100ohm", {29'd0, driveCode}, 32'd3);
    writeReg(8'h18, 32'h0001_0000);
    check("R5 power off", {30'd0, dllEnable, phyPowerOn}, 32'd2);
  endtask

  task automatic testClockFields();
    writeReg(8'h00, 32'hFFFF_0000);
    writeReg(8'h00, 32'h3F80_3C80);
    check("R7 tap sel", {28'd0, tapDelaySel}, 32'd9);
    check("R7 tap en", {31'd0, tapDelayEn}, 32'd1);
    check("R7 freq 150", {30'd0, freqSel}, 32'd3);
    writeReg(8'h00, 32'h3000_1000);
    check("R7 freq 50", {30'd0, freqSel}, 32'd1);
    check("R7 tap sel kept", {28'd0, tapDelaySel}, 32'd9);
  endtask

  task automatic testStatus();
    logic [31:0] v;
    calDoneIn = 1'b1; dllReadyIn = 1'b0;
    readReg(8'h20, v, "R8");
    check("R8 cal only", v, 32'h0000_0040);
    calDoneIn = 1'b1; dllReadyIn = 1'b1;
    readReg(8'h20, v, "R8");
    check("R8 both", v, 32'h0000_0060);
    calDoneIn = 1'b0; dllReadyIn = 1'b1;
    readReg(8'h20, v, "R8");
    check("R8 dll only", v, 32'h0000_0020);
  endtask

  task automatic testIgnored();
    logic [31:0] v;
    writeReg(8'h20, 32'hFFFF_FFFF);
    writeReg(8'h1C, 32'hFFFF_FFFF);
    writeReg(8'h40, 32'hFFFF_FFFF);
    writeReg(8'h02, 32'hFFFF_FFFF);
    writeReg(8'h19, 32'hFFFF_FFFF);
    checkAllRegs("R9 regs unchanged");
    check("R9 pins unchanged", {30'd0, dllEnable, phyPowerOn}, 32'd2);
    readReg(8'h1C, v, "R9");
    check("R9 unmapped read", v, 32'd0);
    readReg(8'h02, v, "R9");
    check("R9 misaligned read", v, 32'd0);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!finished) begin
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 7; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testMaskedWrite();
    testIndependent();
    testPowerFields();
    testClockFields();
    testStatus();
    testIgnored();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule